// File: doc/BRIEF.md
# Flash Program Buffer Status Unit

This unit sits between a CPU register bus and the programming engine of an embedded flash. Software writes data words into a two-entry write buffer. The unit hands those words to the engine in arrival order over a valid/ready handshake. Writing to a full buffer does not stall the bus. The word is dropped and a sticky data-loss flag is raised instead.

An 8-bit status register collects several flags:
- a sticky erase-error flag, set by a pulse from the engine;
- a sticky program-error flag, set by a pulse from the engine;
- a sticky data-loss flag, set by an overrun;
- a live busy flag, high while the engine works or while the flash clocks are not yet ready;
- a live buffer-full flag.

The sticky flags are cleared by writing one to them, but only while busy is low. A control register holds the enable for an interrupt request. That request is raised while the buffer has a free entry.

A 4-bit prescaler register sets how often a one-cycle pacing tick goes to the engine.

Top module: `flash_wrbuf_status`

## Requirements
- R1: After reset the status, prescaler and control registers read 0, the interrupt request is 0 and no word is offered to the engine.
- R2: The register map is: address 0 is the data port, which reads 0; address 1 is status; address 2 is the prescaler; address 3 is control, with bit 0 as the interrupt enable. Status bits 7..5 and prescaler bits 7..4 read 0. A write to status bit 2 (busy) or bit 3 (full) has no effect.
- R3: Words written to address 0 are presented on `eng_data` with `eng_valid` high, in write order. Each is consumed in a cycle where `eng_valid` and `eng_ready` are both high.
- R4: Status bit 3 (full) reads 1 exactly when both buffer entries hold words.
- R5: A data write while full is judged by the fullness at the start of that cycle. It discards the word and sets status bit 4 (data loss). The buffered words and their order are kept.
- R6: Writing 1 to status bit 0 (erase error), bit 1 (program error) or bit 4 clears that bit while busy is 0. Writing 0 leaves it unchanged.
- R7: Status bit 2 (busy) reads 1 while `eng_busy` is 1 or `flash_clk_ok` is 0. While it is 1, a write-one clear leaves the sticky bits set.
- R8: A one-cycle pulse on `eng_erase_err` sets bit 0, and one on `eng_prog_err` sets bit 1. A set in the same cycle as a clear wins.
- R9: `irq` is 1 when the control enable is 1 and the buffer is not full, and is 0 otherwise.
- R10: With divider value D, `tick` is high for one cycle every D+1 cycles. Writing the prescaler restarts the count, so the first tick comes D cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational on bus_addr) |
| eng_valid | output | 1 | Buffered word available to engine |
| eng_data | output | 16 | Oldest buffered word |
| eng_ready | input | 1 | Engine takes the offered word |
| eng_busy | input | 1 | Engine programming or erasing |
| flash_clk_ok | input | 1 | Flash clocks ready |
| eng_prog_err | input | 1 | Program error pulse |
| eng_erase_err | input | 1 | Erase error pulse |
| irq | output | 1 | Buffer-has-room interrupt request |
| tick | output | 1 | Prescaler pacing tick |

## Verification
A wrong buffer count or pointer shows up at the ports within one cycle. It appears as a wrong full bit, a wrong irq level, or a word out of order or repeated on `eng_data` at the next drain. A sticky flag held in the wrong state is visible on the next status read. This matters most in the cycle after a busy-blocked clear or a set/clear collision. A prescaler counter that is off by one moves the tick pattern, and that is seen within D+1 cycles of a divider write.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int ADDR_W = 2;
  localparam int NFLAG  = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PSC  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int B_ERASE = 0;
  localparam int B_PROG  = 1;
  localparam int B_BUSY  = 2;
  localparam int B_FULL  = 3;
  localparam int B_LOSS  = 4;

  // sticky flag indices
  localparam int F_ERASE = 0;
  localparam int F_PROG  = 1;
  localparam int F_LOSS  = 2;

  function automatic logic [7:0] pack_status(input logic [NFLAG-1:0] sticky,
                                             input logic busy, input logic full);
    logic [7:0] s;
    s = 8'h00;
    s[B_ERASE] = sticky[F_ERASE];
    s[B_PROG]  = sticky[F_PROG];
    s[B_BUSY]  = busy;
    s[B_FULL]  = full;
    s[B_LOSS]  = sticky[F_LOSS];
    return s;
  endfunction

  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr, input logic busy);
    return set | (q & ~(clr & ~busy));
  endfunction

  function automatic logic psc_hit(input logic [3:0] cnt, input logic [3:0] div);
    return cnt == div;
  endfunction
endpackage

// File: rtl/fwb_buffer.sv
module fwb_buffer #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          valid,
  output logic          full,
  output logic          overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign valid   = (count != '0);
  assign push    = push_req & ~full;
  assign overrun = push_req & full;
  assign dout    = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (push && wr_ptr == PTR_W'(i)) mem[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_overrun_keeps_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !pop) |=> full);
  p_pop_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> valid);
endmodule

// File: rtl/fwb_status.sv
module fwb_status
  import fwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= sticky_next(flags[i], set[i], clr[i], busy);
    end

    p_clear_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && flags[i] && clr[i] && !set[i]) |=> flags[i]);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && clr[i] && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/fwb_prescaler.sv
module fwb_prescaler
  import fwb_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = psc_hit(cnt, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      cnt <= '0;
    end else if (load) begin
      div <= load_val;
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !load) |=> !tick);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !tick);
endmodule

// File: rtl/flash_wrbuf_status.sv
module flash_wrbuf_status
  import fwb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          eng_valid,
  output logic [DW-1:0] eng_data,
  input  logic          eng_ready,
  input  logic          eng_busy,
  input  logic          flash_clk_ok,
  input  logic          eng_prog_err,
  input  logic          eng_erase_err,
  output logic          irq,
  output logic          tick
);
  localparam int DEPTH = 2;
  localparam int DIV_W = 4;

  reg_sel_e         sel;
  logic             wr_data, wr_stat, wr_psc, wr_ctrl;
  logic             busy, full, overrun, pop, irq_en;
  logic [NFLAG-1:0] set_v, clr_v, sticky;
  logic [DIV_W-1:0] div;
  logic [7:0]       stat_byte;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_data = bus_wr && sel == SEL_DATA;
  assign wr_stat = bus_wr && sel == SEL_STAT;
  assign wr_psc  = bus_wr && sel == SEL_PSC;
  assign wr_ctrl = bus_wr && sel == SEL_CTRL;

  assign busy = eng_busy | ~flash_clk_ok;
  assign pop  = eng_valid & eng_ready;

  fwb_buffer #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push_req(wr_data), .push_data(bus_wdata),
    .pop(pop), .dout(eng_data), .valid(eng_valid), .full(full),
    .overrun(overrun)
  );

  assign set_v[F_ERASE] = eng_erase_err;
  assign set_v[F_PROG]  = eng_prog_err;
  assign set_v[F_LOSS]  = overrun;
  assign clr_v[F_ERASE] = wr_stat & bus_wdata[B_ERASE];
  assign clr_v[F_PROG]  = wr_stat & bus_wdata[B_PROG];
  assign clr_v[F_LOSS]  = wr_stat & bus_wdata[B_LOSS];

  fwb_status u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .set(set_v), .clr(clr_v),
    .flags(sticky)
  );

  fwb_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .load(wr_psc), .load_val(bus_wdata[DIV_W-1:0]),
    .div(div), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (wr_ctrl) irq_en <= bus_wdata[0];
  end

  assign irq       = irq_en & ~full;
  assign stat_byte = pack_status(sticky, busy, full);

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_STAT: bus_rdata[7:0]       = stat_byte;
      SEL_PSC:  bus_rdata[DIV_W-1:0] = div;
      SEL_CTRL: bus_rdata[0]         = irq_en;
      default:  bus_rdata            = '0;
    endcase
  end

  p_overrun_flags_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> sticky[F_LOSS]);
  p_irq_off_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && eng_valid && !pop && !overrun) |=> !irq);
endmodule

// File: tb/flash_wrbuf_status_tb.sv
module flash_wrbuf_status_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        eng_valid, eng_ready = 0;
  logic [15:0] eng_data;
  logic        eng_busy = 0, flash_clk_ok = 1, eng_prog_err = 0, eng_erase_err = 0;
  logic        irq, tick;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  flash_wrbuf_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_valid(eng_valid),
    .eng_data(eng_data), .eng_ready(eng_ready), .eng_busy(eng_busy),
    .flash_clk_ok(flash_clk_ok), .eng_prog_err(eng_prog_err),
    .eng_erase_err(eng_erase_err), .irq(irq), .tick(tick)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drain_one(output logic [15:0] d, output logic v);
    @(negedge clk);
    #1;
    v = eng_valid; d = eng_data;
    eng_ready = 1;
    @(negedge clk);
    eng_ready = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd1, d); check(d, 0, "R1 status");
    rd(2'd2, d); check(d, 0, "R1 prescaler");
    rd(2'd3, d); check(d, 0, "R1 control");
    check(irq, 0, "R1 irq");
    check(eng_valid, 0, "R1 valid");
    rd(2'd0, d); check(d, 0, "R2 data reads zero");
  endtask

  task automatic t_fill_and_drain;
    logic [15:0] d; logic v;
    wr(2'd3, 16'h0001);
    check(irq, 1, "R9 irq with room");
    wr(2'd0, 16'hA1A1);
    rd(2'd1, d); check(d[3], 0, "R4 one entry not full");
    wr(2'd0, 16'hB2B2);
    rd(2'd1, d); check(d[3], 1, "R4 full");
    check(irq, 0, "R9 irq off when full");
    wr(2'd1, 16'h00FF);
    rd(2'd1, d); check(d, 16'h0008, "R2 ro bits unaffected");
    drain_one(d, v);
    check(v, 1, "R3 valid"); check(d, 16'hA1A1, "R3 first word");
    check(irq, 1, "R9 irq back");
    drain_one(d, v); check(d, 16'hB2B2, "R3 second word");
    #1; check(eng_valid, 0, "R3 empty");
  endtask

  task automatic t_overrun;
    logic [15:0] d; logic v;
    wr(2'd0, 16'h1111);
    wr(2'd0, 16'h2222);
    wr(2'd0, 16'h3333);
    rd(2'd1, d); check(d, 16'h0018, "R5 loss and full");
    drain_one(d, v); check(d, 16'h1111, "R5 order kept 1");
    drain_one(d, v); check(d, 16'h2222, "R5 order kept 2");
    #1; check(eng_valid, 0, "R5 dropped word absent");
    wr(2'd1, 16'h0000);
    rd(2'd1, d); check(d[4], 1, "R6 write zero no effect");
    wr(2'd1, 16'h0010);
    rd(2'd1, d); check(d, 0, "R6 loss cleared");
  endtask

  task automatic t_errors_busy;
    logic [15:0] d;
    @(negedge clk); eng_erase_err = 1; eng_prog_err = 1;
    @(negedge clk); eng_erase_err = 0; eng_prog_err = 0;
    rd(2'd1, d); check(d, 16'h0003, "R8 pulses set bits");
    eng_busy = 1;
    rd(2'd1, d); check(d[2], 1, "R7 busy from engine");
    wr(2'd1, 16'h0013);
    rd(2'd1, d); check(d, 16'h0007, "R7 clear blocked");
    eng_busy = 0; flash_clk_ok = 0;
    wr(2'd1, 16'h0003);
    rd(2'd1, d); check(d, 16'h0007, "R7 clear blocked clocks");
    flash_clk_ok = 1;
    wr(2'd1, 16'h0001);
    rd(2'd1, d); check(d, 16'h0002, "R6 erase cleared alone");
    @(negedge clk);
    bus_wr = 1; bus_addr = 2'd1; bus_wdata = 16'h0002; eng_prog_err = 1;
    @(negedge clk);
    bus_wr = 0; eng_prog_err = 0;
    rd(2'd1, d); check(d, 16'h0002, "R8 set wins");
    wr(2'd1, 16'h0002);
    rd(2'd1, d); check(d, 0, "R6 prog cleared");
  endtask

  task automatic t_prescaler;
    logic [15:0] d;
    int bad;
    wr(2'd2, 16'h00F3);
    rd(2'd2, d); check(d, 16'h0003, "R2 prescaler upper bits");
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (tick != ((i % 4) == 3)) bad++;
    end
    check(bad, 0, "R10 period four");
    wr(2'd2, 16'h0000);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (tick != 1) bad++;
    end
    check(bad, 0, "R10 divider zero every cycle");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fill_and_drain;
    t_overrun;
    t_errors_busy;
    t_prescaler;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule